// File: doc/BRIEF.md
# Shared-Buffer First-Stage Cell Switch with Pulled Subqueues

This block is the first stage of a two-stage cell fabric. Each of its N_IN inputs may present one fixed-size cell per cycle with a destination tag. Every cell is stored in one common cell memory of DEPTH slots. It is then linked onto the subqueue that serves its final fabric port. Each local output feeds one downstream switch, and each output holds one subqueue per port of that downstream switch. So every final port of the whole fabric has its own queue, and any input can feed any queue.

Transmission is pulled by the downstream side, not pushed by a local scheduler. For each output, the downstream controller issues a grant naming one of that output's subqueues. The block dequeues the head cell of that subqueue, drives it on the output's cell lane, and returns its slot to the free pool. Each occupancy change is reported back on a status lane. There is one lane per subqueue, and it carries the new count. The downstream controller always sees current queue depths.

Free slots are held in a ring of slot numbers. A small state machine has two states. POOL_FILL is entered at reset and writes one slot number into the ring per cycle for DEPTH cycles. It then takes the transition to POOL_RUN, where the whole pool becomes available and stays available until the next reset. Arrivals that find no free slot are dropped and counted.

Top module: `shared_buf_switch`

## Requirements
- R1: While reset is applied, out_valid, grant_err and stat_valid are all low and loss_count is zero.
- R2: During the first DEPTH cycles after reset is released (state POOL_FILL), every arriving cell is dropped and adds one to loss_count.
- R3: in_dest for input i is {output, subqueue}, with the output number in the upper OUT_W bits and the subqueue in the lower SUB_W bits. A stored cell leaves only on that output, and only in answer to a grant naming that subqueue.
- R4: Each subqueue is first-in first-out. Cells that arrive in the same cycle are linked in ascending input index order.
- R5: A grant on output o (grant_valid[o], with grant_sub naming the subqueue) to a non-empty subqueue removes the head cell. That cell appears on out_cell lane o with out_valid[o] high in the cycle that follows the grant cycle.
- R6: A grant to an empty subqueue removes nothing and leaves out_valid[o] low. It raises grant_err[o] for exactly the following cycle.
- R7: Status lane q = output*N_SUB + subqueue rises for one cycle, in the cycle after any enqueue or dequeue on that subqueue, with stat_count equal to the new occupancy. Lanes of untouched subqueues stay low.
- R8: Arrivals in one cycle are granted slots from the free count held at the start of the cycle, lower inputs first. The surplus arrivals are dropped and added to loss_count. A slot freed by a dequeue can be reused from the next cycle on.
- R9: No slot is lost. After every subqueue is drained, all DEPTH slots can be filled again with no drop.
- R10: A dequeue and one or more enqueues on the same subqueue in the same cycle are all honoured, and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Cell present on each input |
| in_dest | input | N_IN*DEST_W | Per-input destination {output, subqueue} |
| in_cell | input | N_IN*CELL_W | Per-input cell word |
| grant_valid | input | N_OUT | Downstream grant per output |
| grant_sub | input | N_OUT*SUB_W | Subqueue named by each grant |
| out_valid | output | N_OUT | Cell on output lane |
| out_cell | output | N_OUT*CELL_W | Dequeued cell per output |
| grant_err | output | N_OUT | Grant named an empty subqueue |
| stat_valid | output | N_OUT*N_SUB | Subqueue occupancy changed |
| stat_count | output | N_OUT*N_SUB*CNT_W | New occupancy per subqueue lane |
| loss_count | output | LOSS_W | Total dropped arrivals |

## Verification
Out_valid, out_cell, grant_err, every stat lane and loss_count all settle one clock edge after the cycle that carried the arrival or grant. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then compares every output on the next falling edge. Its expected values come from a reference queue per subqueue and a reference free-slot count. The reference counts slots freed in a cycle only from the next cycle on, so the outcome of every drop and reuse is settled before the edge it is checked against.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Pool life cycle: slot ring being written, then open for use.
    typedef enum logic {
        POOL_FILL = 1'b0,
        POOL_RUN  = 1'b1
    } pool_state_e;

    // Bit width of an index over n items, at least one bit.
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sbs_free_list.sv
module sbs_free_list
    import sbs_pkg::*;
#(
    parameter int DEPTH  = 64,   // power of two: pointers wrap naturally
    parameter int N_POP  = 4,
    parameter int N_PUSH = 4,
    localparam int AW = bits_for(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(N_POP + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     pop_num,
    input  logic [N_PUSH-1:0] push_vld,
    input  logic [N_PUSH*AW-1:0] push_slot,
    output logic [N_POP*AW-1:0]  peek_slot,
    output logic [CW-1:0]     avail
);
    pool_state_e   state_q, state_d;
    logic [AW-1:0] ring_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q, fill_q;
    logic [CW-1:0] cnt_q, push_num;
    logic [AW-1:0] push_pos [N_PUSH];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POOL_FILL: if (fill_q == AW'(DEPTH - 1)) state_d = POOL_RUN;
            POOL_RUN:  state_d = POOL_RUN;
        endcase
    end

    // State register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POOL_FILL;
            rd_q    <= '0;
            wr_q    <= '0;
            fill_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                POOL_FILL: begin
                    fill_q <= fill_q + AW'(1);
                    if (state_d == POOL_RUN) cnt_q <= CW'(DEPTH);
                end
                POOL_RUN: begin
                    rd_q  <= rd_q + AW'(pop_num);
                    wr_q  <= wr_q + AW'(push_num);
                    cnt_q <= cnt_q + push_num - CW'(pop_num);
                end
            endcase
        end
    end

    // Returned slots land at consecutive ring positions
    always_comb begin
        push_num = '0;
        for (int j = 0; j < N_PUSH; j++) begin
            push_pos[j] = wr_q + AW'(push_num);
            if (push_vld[j]) push_num = push_num + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == POOL_FILL) begin
            ring_q[fill_q] <= fill_q;
        end else begin
            for (int j = 0; j < N_PUSH; j++)
                if (push_vld[j]) ring_q[push_pos[j]] <= push_slot[j*AW +: AW];
        end
    end

    // Output process
    always_comb begin
        for (int k = 0; k < N_POP; k++)
            peek_slot[k*AW +: AW] = ring_q[rd_q + AW'(k)];
        unique case (state_q)
            POOL_FILL: avail = '0;
            POOL_RUN:  avail = cnt_q;
        endcase
    end

    assert_pop_within_pool_R8: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_num) <= avail);

endmodule

// File: rtl/sbs_cell_store.sv
module sbs_cell_store
    import sbs_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CELL_W = 16,
    parameter int N_WR   = 4,
    parameter int N_RD   = 4,
    localparam int AW = bits_for(DEPTH)
)(
    input  logic                   clk,
    input  logic [N_WR-1:0]        wr_en,
    input  logic [N_WR*AW-1:0]     wr_slot,
    input  logic [N_WR*CELL_W-1:0] wr_data,
    input  logic [N_RD*AW-1:0]     rd_slot,
    output logic [N_RD*CELL_W-1:0] rd_data
);
    logic [CELL_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_WR; i++)
            if (wr_en[i]) mem_q[wr_slot[i*AW +: AW]] <= wr_data[i*CELL_W +: CELL_W];
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        assign rd_data[r*CELL_W +: CELL_W] = mem_q[rd_slot[r*AW +: AW]];
    end

endmodule

// File: rtl/sbs_queue_ctrl.sv
module sbs_queue_ctrl
    import sbs_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_SUB  = 4,
    parameter int DEPTH  = 64,
    parameter int LOSS_W = 16,
    localparam int OUT_W  = bits_for(N_OUT),
    localparam int SUB_W  = bits_for(N_SUB),
    localparam int DEST_W = OUT_W + SUB_W,
    localparam int NQ     = N_OUT * N_SUB,
    localparam int AW     = bits_for(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PW     = $clog2(N_IN + 1)
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN-1:0]       in_valid,
    input  logic [N_IN*DEST_W-1:0] in_dest,
    input  logic [N_OUT-1:0]      grant_valid,
    input  logic [N_OUT*SUB_W-1:0] grant_sub,
    input  logic [CNT_W-1:0]      avail,
    input  logic [N_IN*AW-1:0]    peek_slot,
    output logic [PW-1:0]         pop_num,
    output logic [N_IN-1:0]       wr_en,
    output logic [N_IN*AW-1:0]    wr_slot,
    output logic [N_OUT-1:0]      deq_ok,
    output logic [N_OUT-1:0]      deq_err,
    output logic [N_OUT*AW-1:0]   deq_slot,
    output logic [NQ-1:0]         stat_valid,
    output logic [NQ*CNT_W-1:0]   stat_count,
    output logic [LOSS_W-1:0]     loss_count
);
    logic [AW-1:0]    head_q [NQ], tail_q [NQ], head_d [NQ], tail_d [NQ];
    logic [CNT_W-1:0] cnt_q [NQ], cnt_d [NQ];
    logic [AW-1:0]    next_q [DEPTH];
    logic [NQ-1:0]    touch;
    logic [N_IN-1:0]  link_we;
    logic [AW-1:0]    link_at [N_IN], link_to [N_IN];
    logic [PW-1:0]    drop_num;

    // Dequeues first, then arrivals in ascending input order
    always_comb begin
        head_d  = head_q;
        tail_d  = tail_q;
        cnt_d   = cnt_q;
        touch   = '0;
        deq_ok  = '0;
        deq_err = '0;
        for (int o = 0; o < N_OUT; o++) begin
            int q;
            q = o * N_SUB + int'(grant_sub[o*SUB_W +: SUB_W]);
            deq_slot[o*AW +: AW] = head_q[q];
            if (grant_valid[o]) begin
                if (cnt_q[q] != '0) begin
                    deq_ok[o] = 1'b1;
                    cnt_d[q]  = cnt_q[q] - CNT_W'(1);
                    head_d[q] = next_q[head_q[q]];
                    touch[q]  = 1'b1;
                end else begin
                    deq_err[o] = 1'b1;
                end
            end
        end
        pop_num  = '0;
        drop_num = '0;
        link_we  = '0;
        wr_en    = '0;
        wr_slot  = '0;
        for (int i = 0; i < N_IN; i++) begin
            int q;
            logic [AW-1:0] s;
            link_at[i] = '0;
            link_to[i] = '0;
            q = int'(in_dest[i*DEST_W + SUB_W +: OUT_W]) * N_SUB
              + int'(in_dest[i*DEST_W +: SUB_W]);
            s = peek_slot[int'(pop_num)*AW +: AW];
            if (in_valid[i]) begin
                if (CNT_W'(pop_num) < avail) begin
                    wr_en[i] = 1'b1;
                    wr_slot[i*AW +: AW] = s;
                    if (cnt_d[q] == '0) begin
                        head_d[q] = s;
                    end else begin
                        link_we[i] = 1'b1;
                        link_at[i] = tail_d[q];
                        link_to[i] = s;
                    end
                    tail_d[q] = s;
                    cnt_d[q]  = cnt_d[q] + CNT_W'(1);
                    touch[q]  = 1'b1;
                    pop_num   = pop_num + PW'(1);
                end else begin
                    drop_num = drop_num + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                head_q[q] <= '0;
                tail_q[q] <= '0;
                cnt_q[q]  <= '0;
            end
            stat_valid <= '0;
            stat_count <= '0;
            loss_count <= '0;
        end else begin
            head_q     <= head_d;
            tail_q     <= tail_d;
            cnt_q      <= cnt_d;
            stat_valid <= touch;
            for (int q = 0; q < NQ; q++)
                stat_count[q*CNT_W +: CNT_W] <= cnt_d[q];
            loss_count <= loss_count + LOSS_W'(drop_num);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_IN; i++)
            if (link_we[i]) next_q[link_at[i]] <= link_to[i];
    end

    // Free slots plus queued cells always account for the whole pool
    int held_sum;
    always_comb begin
        held_sum = int'(avail);
        for (int q = 0; q < NQ; q++) held_sum = held_sum + int'(cnt_q[q]);
    end

    assert_pool_conserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (held_sum == DEPTH) || (held_sum == 0));

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        assert_stat_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] != $past(cnt_q[g])) |-> stat_valid[g]);
        assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= CNT_W'(DEPTH));
    end

endmodule

// File: rtl/shared_buf_switch.sv
module shared_buf_switch
    import sbs_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_SUB  = 4,
    parameter int DEPTH  = 64,
    parameter int CELL_W = 16,
    parameter int LOSS_W = 16,
    localparam int OUT_W  = bits_for(N_OUT),
    localparam int SUB_W  = bits_for(N_SUB),
    localparam int DEST_W = OUT_W + SUB_W,
    localparam int NQ     = N_OUT * N_SUB,
    localparam int CNT_W  = $clog2(DEPTH + 1)
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         in_valid,
    input  logic [N_IN*DEST_W-1:0]  in_dest,
    input  logic [N_IN*CELL_W-1:0]  in_cell,
    input  logic [N_OUT-1:0]        grant_valid,
    input  logic [N_OUT*SUB_W-1:0]  grant_sub,
    output logic [N_OUT-1:0]        out_valid,
    output logic [N_OUT*CELL_W-1:0] out_cell,
    output logic [N_OUT-1:0]        grant_err,
    output logic [NQ-1:0]           stat_valid,
    output logic [NQ*CNT_W-1:0]     stat_count,
    output logic [LOSS_W-1:0]       loss_count
);
    localparam int AW = bits_for(DEPTH);
    localparam int PW = $clog2(N_IN + 1);

    logic [PW-1:0]           pop_num;
    logic [CNT_W-1:0]        avail;
    logic [N_IN*AW-1:0]      peek_slot, wr_slot;
    logic [N_IN-1:0]         wr_en;
    logic [N_OUT-1:0]        deq_ok, deq_err;
    logic [N_OUT*AW-1:0]     deq_slot;
    logic [N_OUT*CELL_W-1:0] rd_data;

    sbs_free_list #(.DEPTH(DEPTH), .N_POP(N_IN), .N_PUSH(N_OUT)) u_free (
        .clk(clk), .rst_n(rst_n), .pop_num(pop_num), .push_vld(deq_ok),
        .push_slot(deq_slot), .peek_slot(peek_slot), .avail(avail)
    );

    sbs_queue_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .N_SUB(N_SUB), .DEPTH(DEPTH),
                     .LOSS_W(LOSS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .grant_valid(grant_valid), .grant_sub(grant_sub), .avail(avail),
        .peek_slot(peek_slot), .pop_num(pop_num), .wr_en(wr_en), .wr_slot(wr_slot),
        .deq_ok(deq_ok), .deq_err(deq_err), .deq_slot(deq_slot),
        .stat_valid(stat_valid), .stat_count(stat_count), .loss_count(loss_count)
    );

    sbs_cell_store #(.DEPTH(DEPTH), .CELL_W(CELL_W), .N_WR(N_IN), .N_RD(N_OUT)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(in_cell),
        .rd_slot(deq_slot), .rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_cell  <= '0;
            grant_err <= '0;
        end else begin
            out_valid <= deq_ok;
            grant_err <= deq_err;
            for (int o = 0; o < N_OUT; o++)
                if (deq_ok[o]) out_cell[o*CELL_W +: CELL_W] <= rd_data[o*CELL_W +: CELL_W];
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        assert_out_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> $past(grant_valid[g]));
        assert_err_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grant_err[g] |-> $past(grant_valid[g]));
        assert_err_excludes_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_valid[g] && grant_err[g]));
    end

endmodule

// File: tb/shared_buf_switch_bench.sv
module shared_buf_switch_bench;
    localparam int NI = 4, NO = 4, NS = 4, DEPTH = 64, CW = 16, LW = 16;
    localparam int QN = 16, SW = 2, DW = 4, KW = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic [NI-1:0]   in_valid;
    logic [NI*DW-1:0] in_dest;
    logic [NI*CW-1:0] in_cell;
    logic [NO-1:0]   grant_valid;
    logic [NO*SW-1:0] grant_sub;
    logic [NO-1:0]   out_valid, grant_err;
    logic [NO*CW-1:0] out_cell;
    logic [QN-1:0]   stat_valid;
    logic [QN*KW-1:0] stat_count;
    logic [LW-1:0]   loss_count;

    int vectors = 0, misses = 0, free_ref = 0, loss_ref = 0, cell_seq = 1;
    bit pool_on = 1'b0;
    logic [CW-1:0] model [QN][$];

    shared_buf_switch #(.N_IN(NI), .N_OUT(NO), .N_SUB(NS), .DEPTH(DEPTH),
                        .CELL_W(CW), .LOSS_W(LW)) u_shared_buf_switch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_cell(in_cell), .grant_valid(grant_valid), .grant_sub(grant_sub),
        .out_valid(out_valid), .out_cell(out_cell), .grant_err(grant_err),
        .stat_valid(stat_valid), .stat_count(stat_count), .loss_count(loss_count)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dst(int o, int s);
        return DW'(o * NS + s);
    endfunction

    // One cycle: drive at a falling edge, one rising edge, compare at next falling edge
    task automatic do_cycle(string tag, logic [NI-1:0] iv, logic [NI*DW-1:0] idst,
                            logic [NO-1:0] gv, logic [NO*SW-1:0] gs);
        logic [NO-1:0] e_ov, e_err;
        logic [CW-1:0] e_cell [NO];
        logic [QN-1:0] touched;
        int room, used, freed;
        e_ov = '0; e_err = '0; touched = '0; used = 0; freed = 0;
        for (int o = 0; o < NO; o++) begin
            int q;
            q = o * NS + int'(gs[o*SW +: SW]);
            e_cell[o] = '0;
            if (gv[o]) begin
                if (model[q].size() > 0) begin
                    e_ov[o] = 1'b1;
                    e_cell[o] = model[q].pop_front();
                    touched[q] = 1'b1;
                    freed++;
                end else begin
                    e_err[o] = 1'b1;
                end
            end
        end
        room = pool_on ? free_ref : 0;
        for (int i = 0; i < NI; i++) begin
            in_cell[i*CW +: CW] = CW'(cell_seq);
            cell_seq++;
            if (iv[i]) begin
                if (used < room) begin
                    int q;
                    q = int'(idst[i*DW +: DW]);
                    model[q].push_back(in_cell[i*CW +: CW]);
                    touched[q] = 1'b1;
                    used++;
                end else begin
                    loss_ref++;
                end
            end
        end
        free_ref = free_ref - used + freed;
        in_valid = iv; in_dest = idst; grant_valid = gv; grant_sub = gs;
        @(posedge clk);
        @(negedge clk);
        in_valid = '0; grant_valid = '0;
        for (int o = 0; o < NO; o++) begin
            check(tag, "out_valid R5", out_valid[o], e_ov[o]);
            if (e_ov[o]) check(tag, "out_cell R5", out_cell[o*CW +: CW], e_cell[o]);
            check(tag, "grant_err R6", grant_err[o], e_err[o]);
        end
        for (int q = 0; q < QN; q++) begin
            check(tag, "stat_valid R7", stat_valid[q], touched[q]);
            if (touched[q]) check(tag, "stat_count R7", stat_count[q*KW +: KW], model[q].size());
        end
        check(tag, "loss_count R8", loss_count, loss_ref);
    endtask

    task automatic drain(string tag);
        for (int guard = 0; guard < 200; guard++) begin
            logic [NO-1:0] gv;
            logic [NO*SW-1:0] gs;
            gv = '0; gs = '0;
            for (int o = 0; o < NO; o++)
                for (int s = 0; s < NS; s++)
                    if (!gv[o] && model[o*NS + s].size() > 0) begin
                        gv[o] = 1'b1;
                        gs[o*SW +: SW] = SW'(s);
                    end
            if (gv == '0) break;
            do_cycle(tag, '0, '0, gv, gs);
        end
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "grant_err", grant_err, 0);
        check("R1", "stat_valid", stat_valid, 0);
        check("R1", "loss_count", loss_count, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_init_r2();
        do_cycle("R2", 4'b0101, {dst(3, 3), dst(2, 2), dst(1, 1), dst(0, 0)}, '0, '0);
        repeat (70) @(negedge clk);
        pool_on = 1'b1;
        free_ref = DEPTH;
        check("R2", "loss after fill", loss_count, 2);
    endtask

    task automatic t_route_r3();
        do_cycle("R3", 4'b0100, {dst(0, 0), dst(1, 2), dst(0, 0), dst(0, 0)}, '0, '0);
        do_cycle("R3", '0, '0, 4'b0011, {2'd0, 2'd0, 2'd1, 2'd2});
        do_cycle("R3", '0, '0, 4'b0010, {2'd0, 2'd0, 2'd2, 2'd0});
    endtask

    task automatic t_order_r4();
        do_cycle("R4", 4'b1111, {dst(2, 3), dst(2, 3), dst(2, 3), dst(2, 3)}, '0, '0);
        do_cycle("R4", 4'b1010, {dst(2, 3), dst(0, 0), dst(2, 3), dst(0, 0)}, '0, '0);
        repeat (6) do_cycle("R4", '0, '0, 4'b0100, {2'd0, 2'd3, 2'd0, 2'd0});
    endtask

    task automatic t_parallel_r5();
        do_cycle("R5", 4'b1111, {dst(3, 3), dst(2, 2), dst(1, 1), dst(0, 0)}, '0, '0);
        do_cycle("R5", '0, '0, 4'b1111, {2'd3, 2'd2, 2'd1, 2'd0});
    endtask

    task automatic t_empty_r6();
        do_cycle("R6", '0, '0, 4'b1111, {2'd1, 2'd0, 2'd3, 2'd2});
        do_cycle("R6", '0, '0, '0, '0);
    endtask

    task automatic t_same_r10();
        do_cycle("R10", 4'b0001, {dst(0, 0), dst(0, 0), dst(0, 0), dst(3, 1)}, '0, '0);
        do_cycle("R10", 4'b0011, {dst(0, 0), dst(0, 0), dst(3, 1), dst(3, 1)},
                 4'b1000, {2'd1, 2'd0, 2'd0, 2'd0});
        repeat (3) do_cycle("R10", '0, '0, 4'b1000, {2'd1, 2'd0, 2'd0, 2'd0});
    endtask

    task automatic t_overflow_r8();
        int base;
        base = loss_ref;
        for (int k = 0; k < 17; k++) begin
            logic [NI*DW-1:0] d;
            for (int i = 0; i < NI; i++) d[i*DW +: DW] = dst((k + i) % NO, i);
            do_cycle("R8", 4'hF, d, '0, '0);
        end
        check("R8", "drops at full pool", loss_count, base + 4);
        do_cycle("R8", 4'hF, {dst(1, 1), dst(1, 1), dst(1, 1), dst(1, 1)},
                 4'b0001, {2'd0, 2'd0, 2'd0, 2'd0});
        do_cycle("R8", 4'b0001, {dst(0, 0), dst(0, 0), dst(0, 0), dst(1, 1)}, '0, '0);
        check("R8", "freed slot reused", loss_count, base + 8);
    endtask

    task automatic t_refill_r9();
        int base;
        drain("R9");
        base = loss_ref;
        for (int k = 0; k < 16; k++) begin
            logic [NI*DW-1:0] d;
            for (int i = 0; i < NI; i++) d[i*DW +: DW] = dst(i, k % NS);
            do_cycle("R9", 4'hF, d, '0, '0);
        end
        check("R9", "no drop on refill", loss_count, base);
        drain("R9");
        check("R9", "no drop after drain", loss_count, base);
    endtask

    initial begin
        in_valid = '0; in_dest = '0; in_cell = '0; grant_valid = '0; grant_sub = '0;
        @(negedge clk);
        t_reset_r1();
        t_init_r2();
        t_route_r3();
        t_order_r4();
        t_parallel_r5();
        t_empty_r6();
        t_same_r10();
        drain("R4");
        t_overflow_r8();
        t_refill_r9();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL watchdog R1: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule